// File: doc/BRIEF.md
# Sectored Write-Back Cache Tags

This block keeps tags, state and data for a small two-way set-associative cache in which each 128-byte line is split into four 32-byte sectors. A line owns a single address tag, but every sector has its own valid bit and its own dirty bit. A lookup that matches the tag but lands on an empty sector fetches just that sector and leaves the line where it is. A lookup that matches no tag evicts a line. Only the victim's modified sectors travel back to memory, one 32-byte transfer for each.

The CPU side is a single request port. A request carries read or write, a byte address, a 32-bit write word and byte enables. The memory side has two channels. The first is a sector fill channel: the block raises a request with a sector-aligned address, and a one-cycle pulse returns the 256-bit sector. The second is a sector write-back channel, which uses a valid/ready handshake. Only one memory operation is open at a time. While a miss is being served, the CPU port holds ready low.

Top module: `sect_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready_o` is high, and `rsp_valid_o`, `fill_req_o` and `wb_valid_o` are low, so the first access to any address needs a fill.
- R2: The address (default parameters) is split from the top down as follows: tag in bits [31:9], set in [8:7], sector in [6:5], word within sector in [4:2] and byte in [1:0]. Fill and write-back addresses are sector aligned, with bits [4:0] zero.
- R3: A read whose tag matches and whose sector is valid is answered with `rsp_valid_o` in the cycle after acceptance. It causes no fill and no write-back.
- R4: A tag match on an invalid sector raises one fill for that sector alone. It writes nothing back, and the other sectors of the line keep their contents and state.
- R5: Writes allocate per sector. A missing sector is filled first. Then the bytes selected by `req_be_i` (bit i covers data bits [8i+7:8i] of the addressed word) are merged in and the sector becomes dirty. A write's response carries `rsp_rdata_o` = 0.
- R6: The victim on a tag miss is the first invalid way, checking way 0 before way 1. If both ways are valid, the least-recently-used way is chosen, where every hit and every fill makes the other way the LRU.
- R7: An eviction writes back only the victim's dirty sectors, in ascending sector order. Each one is a separate handshake carrying the sector address and its 256 bits. A clean victim causes no write-back.
- R8: After eviction the new tag is installed with all sectors invalid, so a later access to another sector of the same new line is a sector miss.
- R9: From the acceptance of a miss until its response, `req_ready_o` stays low and only one of `fill_req_o` and `wb_valid_o` is high. `wb_valid_o` holds its address until `wb_ready_i` is seen, and `fill_req_o` holds its address until `fill_valid_i` arrives.
- R10: A read miss is answered one cycle after `fill_valid_i`, returning the requested word from the filled sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Write word |
| req_be_i | input | 4 | Byte enables for the write word |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_rdata_o | output | 32 | Read word (0 for writes) |
| fill_req_o | output | 1 | Sector fill requested |
| fill_addr_o | output | 32 | Sector-aligned fill address |
| fill_valid_i | input | 1 | Fill data present (one-cycle pulse) |
| fill_data_i | input | 256 | Filled sector, byte 0 in bits [7:0] |
| wb_valid_o | output | 1 | Write-back sector present |
| wb_ready_i | input | 1 | Memory takes the write-back sector |
| wb_addr_o | output | 32 | Sector-aligned write-back address |
| wb_data_o | output | 256 | Sector being written back |

## Verification
Two pairs of actions share a cycle. On a write miss, the arrival of fill data and the byte-enable merge of the pending write happen in the same cycle. On an eviction, the acceptance of the last dirty sector coincides with the install of the new tag. The bench triggers the first with write misses that use sparse byte enables, then reads the word back and compares it with a byte-level reference model. It triggers the second by evicting lines that have two dirty sectors, then checks that the next access to the new tag's other sectors is a sector miss. Each write-back address and data is compared in order against the model's expected queue.

// File: rtl/sect_cache_pkg.sv
package sect_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } st_e;
endpackage

// File: rtl/sect_tag_store.sv
module sect_tag_store #(
  parameter int SETS    = 4,
  parameter int SECTORS = 4,
  parameter int TAG_W   = 23,
  parameter int SET_W   = 2,
  parameter int SEC_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [SET_W-1:0]              set_i,
  input  logic                          way_i,
  input  logic [SEC_W-1:0]              sec_i,
  input  logic [TAG_W-1:0]              tag_i,
  input  logic                          touch_i,
  input  logic                          install_i,
  input  logic                          set_vld_i,
  input  logic                          set_dirty_i,
  input  logic                          clr_dirty_i,
  output logic [1:0][TAG_W-1:0]         rd_tag_o,
  output logic [1:0]                    rd_line_vld_o,
  output logic [1:0][SECTORS-1:0]       rd_sec_vld_o,
  output logic [1:0][SECTORS-1:0]       rd_sec_dirty_o,
  output logic                          rd_lru_o
);
  logic [SETS-1:0][1:0][TAG_W-1:0]   tag_q;
  logic [SETS-1:0][1:0]              lv_q;
  logic [SETS-1:0][1:0][SECTORS-1:0] sv_q;
  logic [SETS-1:0][1:0][SECTORS-1:0] sd_q;
  logic [SETS-1:0]                   lru_q;

  assign rd_tag_o       = tag_q[set_i];
  assign rd_line_vld_o  = lv_q[set_i];
  assign rd_sec_vld_o   = sv_q[set_i];
  assign rd_sec_dirty_o = sd_q[set_i];
  assign rd_lru_o       = lru_q[set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      lv_q  <= '0;
      sv_q  <= '0;
      sd_q  <= '0;
      lru_q <= '0;
    end else begin
      if (touch_i)     lru_q[set_i] <= ~way_i;
      if (set_vld_i)   sv_q[set_i][way_i][sec_i] <= 1'b1;
      if (set_dirty_i) sd_q[set_i][way_i][sec_i] <= 1'b1;
      if (clr_dirty_i) sd_q[set_i][way_i][sec_i] <= 1'b0;
      if (install_i) begin
        tag_q[set_i][way_i] <= tag_i;
        lv_q[set_i][way_i]  <= 1'b1;
        sv_q[set_i][way_i]  <= '0;
        sd_q[set_i][way_i]  <= '0;
      end
    end
  end

  // dirty state only on sectors holding data
  p_dirty_in_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_q & ~sv_q) == '0);

  // new tag starts with no valid sector
  p_install_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    install_i |=> (sv_q[$past(set_i)][$past(way_i)] == '0));
endmodule

// File: rtl/sect_data_store.sv
module sect_data_store #(
  parameter int SETS      = 4,
  parameter int SECTORS   = 4,
  parameter int SEC_BYTES = 32,
  parameter int SET_W     = 2,
  parameter int SEC_W     = 2
) (
  input  logic                   clk_i,
  input  logic                   way_i,
  input  logic [SET_W-1:0]       set_i,
  input  logic [SEC_W-1:0]       sec_i,
  input  logic                   we_i,
  input  logic [SEC_BYTES*8-1:0] wdata_i,
  input  logic [SEC_BYTES-1:0]   wmask_i,
  output logic [SEC_BYTES*8-1:0] rd_data_o
);
  localparam int DEPTH = 2 * SETS * SECTORS;
  localparam int IDX_W = 1 + SET_W + SEC_W;

  logic [SEC_BYTES*8-1:0] mem_q [DEPTH];
  logic [SEC_BYTES*8-1:0] merged;
  logic [IDX_W-1:0]       idx;

  assign idx       = {way_i, set_i, sec_i};
  assign rd_data_o = mem_q[idx];

  for (genvar b = 0; b < SEC_BYTES; b++) begin : g_merge
    assign merged[b*8 +: 8] = wmask_i[b] ? wdata_i[b*8 +: 8] : rd_data_o[b*8 +: 8];
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx] <= merged;
  end
endmodule

// File: rtl/sect_cache.sv
module sect_cache
  import sect_cache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int SEC_BYTES = 32,
  parameter int SECTORS   = 4,
  parameter int SETS      = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  output logic                   req_ready_o,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [WORD_W-1:0]      req_wdata_i,
  input  logic [WORD_W/8-1:0]    req_be_i,
  output logic                   rsp_valid_o,
  output logic [WORD_W-1:0]      rsp_rdata_o,
  output logic                   fill_req_o,
  output logic [ADDR_W-1:0]      fill_addr_o,
  input  logic                   fill_valid_i,
  input  logic [SEC_BYTES*8-1:0] fill_data_i,
  output logic                   wb_valid_o,
  input  logic                   wb_ready_i,
  output logic [ADDR_W-1:0]      wb_addr_o,
  output logic [SEC_BYTES*8-1:0] wb_data_o
);
  localparam int BE_W   = WORD_W / 8;
  localparam int SEC_DW = SEC_BYTES * 8;
  localparam int WORDS  = SEC_DW / WORD_W;
  localparam int BOFF_W = $clog2(BE_W);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = $clog2(SEC_BYTES);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SEC_W - SET_W;

  st_e st_q, st_d;

  logic [TAG_W-1:0]  req_tag, r_tag_q;
  logic [SET_W-1:0]  req_set, r_set_q, cur_set;
  logic [SEC_W-1:0]  req_sec, r_sec_q, cur_sec, wb_sec;
  logic [WSEL_W-1:0] req_wsel, r_wsel_q;
  logic              r_write_q, r_way_q, cur_way;
  logic [WORD_W-1:0] r_wdata_q;
  logic [BE_W-1:0]   r_be_q;
  logic [BOFF_W-1:0] unused_byte_off;

  assign req_tag         = req_addr_i[ADDR_W-1 -: TAG_W];
  assign req_set         = req_addr_i[OFF_W+SEC_W +: SET_W];
  assign req_sec         = req_addr_i[OFF_W +: SEC_W];
  assign req_wsel        = req_addr_i[BOFF_W +: WSEL_W];
  assign unused_byte_off = req_addr_i[BOFF_W-1:0];

  logic [1:0][TAG_W-1:0]   rd_tag;
  logic [1:0]              rd_lv;
  logic [1:0][SECTORS-1:0] rd_sv, rd_sd;
  logic                    rd_lru;
  logic [SEC_DW-1:0]       rd_data, wdata, fill_merged;
  logic [SEC_BYTES-1:0]    wmask;
  logic                    we, touch, install, set_vld, set_dirty, clr_dirty;

  logic       idle, acc, hit_any, hit_way, sec_hit, victim, victim_dirty;
  logic [1:0] hit_w;
  logic       rsp_d;
  logic [WORD_W-1:0] rdata_d;

  assign idle        = (st_q == ST_IDLE);
  assign req_ready_o = idle;
  assign acc         = req_valid_i && idle;
  assign cur_set     = idle ? req_set : r_set_q;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = rd_lv[w] && (rd_tag[w] == req_tag);
  end

  assign hit_any      = |hit_w;
  assign hit_way      = hit_w[1];
  assign sec_hit      = hit_any && rd_sv[hit_way][req_sec];
  assign victim       = !rd_lv[0] ? 1'b0 : (!rd_lv[1] ? 1'b1 : rd_lru);
  assign victim_dirty = rd_lv[victim] && (|rd_sd[victim]);
  assign cur_way      = idle ? (hit_any ? hit_way : victim) : r_way_q;

  // lowest dirty sector of the victim goes out first
  always_comb begin
    wb_sec = '0;
    for (int s = SECTORS - 1; s >= 0; s--) begin
      if (rd_sd[r_way_q][s]) wb_sec = SEC_W'(s);
    end
  end

  always_comb begin
    if (idle)              cur_sec = req_sec;
    else if (st_q == ST_WB) cur_sec = wb_sec;
    else                   cur_sec = r_sec_q;
  end

  always_comb begin
    fill_merged = fill_data_i;
    for (int b = 0; b < BE_W; b++) begin
      if (r_write_q && r_be_q[b])
        fill_merged[r_wsel_q*WORD_W + b*8 +: 8] = r_wdata_q[b*8 +: 8];
    end
  end

  always_comb begin
    st_d      = st_q;
    we        = 1'b0;
    touch     = 1'b0;
    install   = 1'b0;
    set_vld   = 1'b0;
    set_dirty = 1'b0;
    clr_dirty = 1'b0;
    wdata     = {WORDS{req_wdata_i}};
    wmask     = '0;
    rsp_d     = 1'b0;
    rdata_d   = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (acc) begin
          if (sec_hit) begin
            touch = 1'b1;
            rsp_d = 1'b1;
            if (req_write_i) begin
              we        = 1'b1;
              set_dirty = 1'b1;
              wmask[req_wsel*BE_W +: BE_W] = req_be_i;
            end else begin
              rdata_d = rd_data[req_wsel*WORD_W +: WORD_W];
            end
          end else if (hit_any) begin
            st_d = ST_FILL;
          end else if (victim_dirty) begin
            st_d = ST_WB;
          end else begin
            install = 1'b1;
            st_d    = ST_FILL;
          end
        end
      end
      ST_WB: begin
        if (wb_ready_i) begin
          clr_dirty = 1'b1;
          if ($countones(rd_sd[r_way_q]) == 1) begin
            install = 1'b1;
            st_d    = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (fill_valid_i) begin
          we        = 1'b1;
          wdata     = fill_merged;
          wmask     = '1;
          set_vld   = 1'b1;
          set_dirty = r_write_q;
          touch     = 1'b1;
          rsp_d     = 1'b1;
          rdata_d   = r_write_q ? '0 : fill_data_i[r_wsel_q*WORD_W +: WORD_W];
          st_d      = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      r_tag_q     <= '0;
      r_set_q     <= '0;
      r_sec_q     <= '0;
      r_wsel_q    <= '0;
      r_way_q     <= 1'b0;
      r_write_q   <= 1'b0;
      r_wdata_q   <= '0;
      r_be_q      <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      st_q        <= st_d;
      rsp_valid_o <= rsp_d;
      rsp_rdata_o <= rdata_d;
      if (acc) begin
        r_tag_q   <= req_tag;
        r_set_q   <= req_set;
        r_sec_q   <= req_sec;
        r_wsel_q  <= req_wsel;
        r_way_q   <= cur_way;
        r_write_q <= req_write_i;
        r_wdata_q <= req_wdata_i;
        r_be_q    <= req_be_i;
      end
    end
  end

  assign wb_valid_o  = (st_q == ST_WB);
  assign wb_addr_o   = {rd_tag[r_way_q], r_set_q, wb_sec, {OFF_W{1'b0}}};
  assign wb_data_o   = rd_data;
  assign fill_req_o  = (st_q == ST_FILL);
  assign fill_addr_o = {r_tag_q, r_set_q, r_sec_q, {OFF_W{1'b0}}};

  sect_tag_store #(
    .SETS(SETS), .SECTORS(SECTORS), .TAG_W(TAG_W), .SET_W(SET_W), .SEC_W(SEC_W)
  ) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(cur_set), .way_i(cur_way), .sec_i(cur_sec),
    .tag_i(idle ? req_tag : r_tag_q),
    .touch_i(touch), .install_i(install), .set_vld_i(set_vld),
    .set_dirty_i(set_dirty), .clr_dirty_i(clr_dirty),
    .rd_tag_o(rd_tag), .rd_line_vld_o(rd_lv), .rd_sec_vld_o(rd_sv),
    .rd_sec_dirty_o(rd_sd), .rd_lru_o(rd_lru)
  );

  sect_data_store #(
    .SETS(SETS), .SECTORS(SECTORS), .SEC_BYTES(SEC_BYTES), .SET_W(SET_W), .SEC_W(SEC_W)
  ) u_data (
    .clk_i(clk_i), .way_i(cur_way), .set_i(cur_set), .sec_i(cur_sec),
    .we_i(we), .wdata_i(wdata), .wmask_i(wmask), .rd_data_o(rd_data)
  );

  // write-back beat held until taken
  p_wb_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wb_ready_i) |=> (wb_valid_o && $stable(wb_addr_o)));

  // fill request held until data arrives
  p_fill_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> (fill_req_o && $stable(fill_addr_o)));

  // consecutive write-back beats climb in sector order
  p_wb_ascending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wb_valid_o && wb_ready_i) && wb_valid_o)
      |-> (wb_addr_o[OFF_W +: SEC_W] > $past(wb_addr_o[OFF_W +: SEC_W])));

  // no new request taken while memory traffic is open
  p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o || wb_valid_o) |-> !req_ready_o);
endmodule

// File: tb/sect_cache_tb.sv
`timescale 1ns/1ps
module sect_cache_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [31:0]  req_addr_i = '0, req_wdata_i = '0;
  logic [3:0]   req_be_i = '0;
  logic         fill_valid_i = 1'b0, wb_ready_i = 1'b0;
  logic [255:0] fill_data_i = '0;
  logic         req_ready_o, rsp_valid_o, fill_req_o, wb_valid_o;
  logic [31:0]  rsp_rdata_o, fill_addr_o, wb_addr_o;
  logic [255:0] wb_data_o;

  always #4 clk = ~clk;

  sect_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_be_i(req_be_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .fill_req_o(fill_req_o), .fill_addr_o(fill_addr_o),
    .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i),
    .wb_valid_o(wb_valid_o), .wb_ready_i(wb_ready_i),
    .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // reference model
  logic [255:0] mem [logic [31:0]];
  logic [22:0]  m_tag [2][4];
  bit           m_lv  [2][4];
  bit           m_sv  [2][4][4];
  bit           m_sd  [2][4][4];
  logic [255:0] m_dat [2][4][4];
  bit           m_lru [4];
  logic [287:0] exp_wb_q[$];
  logic [31:0]  exp_fill_q[$];

  function automatic logic [255:0] sec_init(logic [31:0] a);
    logic [255:0] r;
    for (int w = 0; w < 8; w++) r[w*32 +: 32] = {a[31:5], 3'(w), 2'b00} ^ 32'h5A3C_96E1;
    return r;
  endfunction

  function automatic logic [255:0] mem_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : sec_init(a);
  endfunction

  function automatic logic [31:0] mk(int tag, int set, int sec, int wd);
    return {23'(tag), 2'(set), 2'(sec), 3'(wd), 2'b00};
  endfunction

  function automatic void model(bit wr, logic [31:0] a, logic [31:0] d, logic [3:0] be,
                                output logic [31:0] rdata, output bit hit);
    int set = int'(a[8:7]);
    int sec = int'(a[6:5]);
    int wd  = int'(a[4:2]);
    int way = -1;
    logic [31:0] sa;
    for (int w = 0; w < 2; w++) if (m_lv[w][set] && m_tag[w][set] == a[31:9]) way = w;
    hit = 0;
    if (way < 0) begin
      way = !m_lv[0][set] ? 0 : (!m_lv[1][set] ? 1 : int'(m_lru[set]));
      if (m_lv[way][set]) begin
        for (int s = 0; s < 4; s++) begin
          if (m_sd[way][set][s]) begin
            sa = {m_tag[way][set], 2'(set), 2'(s), 5'b0};
            exp_wb_q.push_back({sa, m_dat[way][set][s]});
            mem[sa] = m_dat[way][set][s];
          end
        end
      end
      m_tag[way][set] = a[31:9];
      m_lv[way][set]  = 1;
      for (int s = 0; s < 4; s++) begin m_sv[way][set][s] = 0; m_sd[way][set][s] = 0; end
    end
    if (m_sv[way][set][sec]) hit = 1;
    else begin
      sa = {a[31:5], 5'b0};
      exp_fill_q.push_back(sa);
      m_dat[way][set][sec] = mem_rd(sa);
      m_sv[way][set][sec] = 1;
    end
    m_lru[set] = (way == 0);
    if (wr) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) m_dat[way][set][sec][wd*32 + b*8 +: 8] = d[b*8 +: 8];
      m_sd[way][set][sec] = 1;
      rdata = '0;
    end else begin
      rdata = m_dat[way][set][sec][wd*32 +: 32];
    end
  endfunction

  // memory responder
  initial begin
    int fcnt = 0;
    logic [287:0] e;
    logic [31:0]  fa;
    forever begin
      @(negedge clk);
      checks++;
      if (wb_valid_o && fill_req_o) begin
        errors++;
        $display("FAIL R9: wb and fill both open, actual 1 expected 0");
      end
      if (wb_ready_i) wb_ready_i = 1'b0;
      else if (wb_valid_o) begin
        if (exp_wb_q.size() == 0) chk(0, "R7 unexpected write-back", {224'b0, wb_addr_o}, '0);
        else begin
          e = exp_wb_q.pop_front();
          chk(wb_addr_o == e[287:256], "R7 R2 write-back address", {224'b0, wb_addr_o}, {224'b0, e[287:256]});
          chk(wb_data_o == e[255:0], "R7 write-back data", wb_data_o, e[255:0]);
        end
        wb_ready_i = 1'b1;
      end
      if (fill_valid_i) begin
        fill_valid_i = 1'b0;
        fcnt = 0;
      end else if (fill_req_o) begin
        fcnt++;
        if (fcnt == 3) begin
          if (exp_fill_q.size() == 0) chk(0, "R3 R4 unexpected fill", {224'b0, fill_addr_o}, '0);
          else begin
            fa = exp_fill_q.pop_front();
            chk(fill_addr_o == fa, "R2 R4 fill address", {224'b0, fill_addr_o}, {224'b0, fa});
          end
          fill_data_i  = mem_rd(fill_addr_o);
          fill_valid_i = 1'b1;
          fcnt = 0;
        end
      end
    end
  end

  task automatic access(bit wr, logic [31:0] a, logic [31:0] d, logic [3:0] be, string rq);
    logic [31:0] exp;
    bit hit;
    int n = 0;
    model(wr, a, d, be, exp, hit);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d; req_be_i = be;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    if (!hit) chk(!req_ready_o && !rsp_valid_o, {rq, " R9 stall on miss"}, {255'b0, req_ready_o}, '0);
    while (!rsp_valid_o && n < 400) begin @(negedge clk); n++; end
    chk(rsp_valid_o, {rq, " response"}, {255'b0, rsp_valid_o}, 256'd1);
    if (hit) chk(n == 0, {rq, " R3 hit latency"}, n, 0);
    chk(rsp_rdata_o == exp, {rq, " data"}, {224'b0, rsp_rdata_o}, {224'b0, exp});
    chk(exp_wb_q.size() == 0 && exp_fill_q.size() == 0, {rq, " R7 R4 memory traffic"},
        exp_wb_q.size() + exp_fill_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++) begin
        m_lv[w][s] = 0; m_lru[s] = 0;
        for (int k = 0; k < 4; k++) begin m_sv[w][s][k] = 0; m_sd[w][s][k] = 0; end
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o, "R1 ready after reset", {255'b0, req_ready_o}, 256'd1);
    chk(!rsp_valid_o && !fill_req_o && !wb_valid_o, "R1 idle outputs",
        {253'b0, rsp_valid_o, fill_req_o, wb_valid_o}, '0);

    access(0, mk(1, 0, 0, 2), 0, 0, "R1 R10 cold read miss");
    access(0, mk(1, 0, 0, 2), 0, 0, "R3 read hit");
    access(0, mk(1, 0, 0, 7), 0, 0, "R3 read hit other word");
    access(0, mk(1, 0, 2, 5), 0, 0, "R4 sector miss");
    access(0, mk(1, 0, 0, 3), 0, 0, "R4 first sector kept");
    access(1, mk(1, 0, 1, 4), 32'hDEAD_BEEF, 4'b0101, "R5 write allocate merge");
    access(0, mk(1, 0, 1, 4), 0, 0, "R5 merged readback");
    access(1, mk(1, 0, 0, 2), 32'h1234_5678, 4'b1111, "R5 write hit");
    access(0, mk(2, 0, 3, 0), 0, 0, "R6 invalid way chosen");
    access(0, mk(3, 0, 1, 1), 0, 0, "R6 R7 lru victim dirty evict");
    access(0, mk(3, 0, 2, 6), 0, 0, "R8 new line sector miss");
    access(0, mk(1, 0, 1, 4), 0, 0, "R7 clean victim written data refetched");
    access(0, mk(1, 0, 0, 2), 0, 0, "R8 R7 sector refetch");
    access(1, mk(5, 3, 3, 7), 32'hA5A5_0F0F, 4'b1000, "R5 single byte write miss");
    access(0, mk(5, 3, 3, 7), 0, 0, "R5 single byte readback");

    for (int i = 0; i < 120; i++) begin
      access(bit'($urandom % 2), mk(int'($urandom % 3) + 1, int'($urandom % 2) + 1,
             int'($urandom % 4), int'($urandom % 8)), $urandom, 4'($urandom), "R6 R7 R8 mixed");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule